// File: doc/BRIEF.md
# Rotating Register File Renamer

This block holds a general register file and a one-bit predicate file. In each file the upper part is a rotating window, and every register number in that window is renamed through a rename base. Software-pipelined loops use it so that each iteration sees last iteration's values one register number higher, without copying any data. Registers below a window are always reached at their own number. The general window starts at register 32 and its size is set by a configuration input. The predicate window covers predicates 16 to 63.

A rotation step moves every value in both windows up by one logical number, and the value at the top of a window wraps to the bottom. At the same step the block writes a supplied bit into the highest rotating predicate, so that bit appears in the lowest rotating predicate after the step. A clear input returns both bases to zero. A bulk load fills all rotating predicates at once. Reads are combinational. Writes are registered.

Top module: `rot_regfile`

## Requirements
- R1: After reset every general register and every predicate reads 0, and both rename bases (`gr_base`, `pr_base`) are 0.
- R2: General registers below 32 and predicates below 16 are never renamed. A value written to such a number reads back at the same number after any number of rotation steps.
- R3: Let S be the effective general window size. For logical number n with 32 <= n < 32+S, the physical register is 32 + ((n-32) + gr_base) mod S. General numbers at or above 32+S are not renamed. Predicates 16..63 map the same way with start 16, size 48 and `pr_base`.
- R4: After one rotation step, the value read at logical n in a window is read at n+1. The value at the highest number of the window is read at the lowest. This applies to both files.
- R5: Each step decrements each base by one, modulo its window size, so 0 goes to size-1. `rot_clear` sets both bases to 0. When `rot_clear` and `rot_step` are high together, the clear wins and the step has no other effect (no rotation, no top-predicate write).
- R6: The effective general window size is `cfg_rot_size`, limited to 32. A size of 0 turns off general renaming and holds `gr_base` at 0.
- R7: A write in the same cycle as a rotation step uses the base from before the step. The written value therefore reads one number higher after the step.
- R8: With `pr_bulk_en` high, bit k of `pr_bulk_val` becomes logical predicate 16+k. This overrides an explicit predicate write to a rotating predicate in the same cycle.
- R9: On a rotation step, `pr_top_in` is written to logical predicate 63 using the old base, so it reads at predicate 16 after the step. This write overrides a bulk load or an explicit write to that predicate in the same cycle.
- R10: The two general read ports and the predicate read port act independently. Each returns data in the same cycle its index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_step | input | 1 | Rotate both windows by one |
| rot_clear | input | 1 | Return both bases to zero |
| cfg_rot_size | input | 6 | General window size, limited to 32 |
| gr_ra_idx | input | 6 | Read port A logical number |
| gr_ra_data | output | 16 | Read port A data |
| gr_rb_idx | input | 6 | Read port B logical number |
| gr_rb_data | output | 16 | Read port B data |
| gr_we | input | 1 | General write enable |
| gr_wa_idx | input | 6 | General write logical number |
| gr_wd | input | 16 | General write data |
| pr_rd_idx | input | 6 | Predicate read logical number |
| pr_rd_val | output | 1 | Predicate read value |
| pr_we | input | 1 | Predicate write enable |
| pr_wa_idx | input | 6 | Predicate write logical number |
| pr_wval | input | 1 | Predicate write value |
| pr_bulk_en | input | 1 | Load all rotating predicates |
| pr_bulk_val | input | 48 | Bulk value, bit k to predicate 16+k |
| pr_top_in | input | 1 | Bit written to predicate 63 on a step |
| gr_base | output | 6 | Current general rename base |
| pr_base | output | 6 | Current predicate rename base |

## Verification
Assertions check the following on every cycle:
- The base counters decrement, wrap and clear as specified.
- A base that is disabled stays at zero.
- Numbers below a window are never remapped, and numbers above the general window are not remapped either.
- Two different logical numbers never land on the same physical register.
- After a step, the lowest predicate holds the supplied top bit.
- After a bulk load, the lowest predicate holds bit 0 of the bulk value.

Some behaviours need the bench's scenarios, which track a logical-view model shifted on each step:
- Values move up by one logical number and wrap at the top of the window.
- A same-cycle write lands one number higher after the step.
- The window bound follows the configured size, including 0 and values above the limit.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] idx_t;

  // Logical to physical number: inside [start, start+size) the offset is
  // rotated by base modulo size; everything else passes through.
  function automatic idx_t rot_map(idx_t lidx, idx_t start, idx_t size, idx_t base);
    logic [IDX_W:0] off;
    if (size == '0) return lidx;
    if (lidx < start) return lidx;
    if ({1'b0, lidx} >= ({1'b0, start} + {1'b0, size})) return lidx;
    off = {1'b0, lidx - start} + {1'b0, base};
    off = off % {1'b0, size};
    return start + off[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  input  logic [BW-1:0] size_i,
  output logic [BW-1:0] base_o
);
  logic [BW-1:0] base_q;
  logic          step_take;
  logic          at_floor;

  assign step_take = step && !clear && (size_i != '0);
  assign at_floor  = (base_q == '0) || (base_q >= size_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                       base_q <= '0;
    else if (clear || size_i == '0)   base_q <= '0;
    else if (step)                    base_q <= at_floor ? size_i - 1'b1 : base_q - 1'b1;
  end

  assign base_o = base_q;

  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (base_q == '0));
  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_take |=> (base_q < $past(size_i)));
  a_r5_step_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && base_q != '0 && base_q < size_i) |=> (base_q == $past(base_q) - 1'b1));
  a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && base_q == '0) |=> (base_q == $past(size_i) - 1'b1));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear && size_i != '0) |=> $stable(base_q));
  a_r6_zero_size_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == '0) |=> (base_q == '0));
endmodule

// File: rtl/rrf_gr_file.sv
module rrf_gr_file
  import rrf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NUM   = 64,
  parameter int AW    = 6,
  parameter int START = 32,
  parameter int SW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] size_i,
  input  logic [SW-1:0] base_i,
  input  logic [AW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa_idx,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] mem [NUM];
  logic [AW-1:0] ra_phys, rb_phys, wa_phys;

  assign ra_phys = AW'(rot_map(idx_t'(ra_idx), idx_t'(START), idx_t'(size_i), idx_t'(base_i)));
  assign rb_phys = AW'(rot_map(idx_t'(rb_idx), idx_t'(START), idx_t'(size_i), idx_t'(base_i)));
  assign wa_phys = AW'(rot_map(idx_t'(wa_idx), idx_t'(START), idx_t'(size_i), idx_t'(base_i)));

  assign ra_data = mem[ra_phys];
  assign rb_data = mem[rb_phys];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa_phys] <= wd;
    end
  end

  a_r2_gr_low_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wa_idx) < START) |-> (wa_phys == wa_idx));
  a_r3_gr_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ra_idx) >= START) |-> (int'(ra_phys) >= START));
  a_r3_gr_above_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rb_idx) >= START + int'(size_i)) |-> (rb_phys == rb_idx));
  a_r10_gr_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx != rb_idx) |-> (ra_phys != rb_phys));
endmodule

// File: rtl/rrf_pr_file.sv
module rrf_pr_file
  import rrf_pkg::*;
#(
  parameter int NUM   = 64,
  parameter int AW    = 6,
  parameter int START = 16,
  parameter int BW    = 6,
  localparam int ROT  = NUM - START
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BW-1:0]  base_i,
  input  logic [AW-1:0]  rd_idx,
  output logic           rd_val,
  input  logic           we,
  input  logic [AW-1:0]  wa_idx,
  input  logic           wval,
  input  logic           bulk_en,
  input  logic [ROT-1:0] bulk_val,
  input  logic           top_en,
  input  logic           top_val,
  output logic           low_val
);
  logic [NUM-1:0] bits_q, bits_d;
  logic [AW-1:0]  rd_phys, wa_phys, top_phys, low_phys;

  assign rd_phys  = AW'(rot_map(idx_t'(rd_idx), idx_t'(START), idx_t'(ROT), idx_t'(base_i)));
  assign wa_phys  = AW'(rot_map(idx_t'(wa_idx), idx_t'(START), idx_t'(ROT), idx_t'(base_i)));
  assign top_phys = AW'(rot_map(idx_t'(NUM - 1), idx_t'(START), idx_t'(ROT), idx_t'(base_i)));
  assign low_phys = AW'(rot_map(idx_t'(START), idx_t'(START), idx_t'(ROT), idx_t'(base_i)));

  assign rd_val  = bits_q[rd_phys];
  assign low_val = bits_q[low_phys];

  // Priority, lowest first: explicit write, bulk load, top write on a step.
  always_comb begin
    bits_d = bits_q;
    if (we) bits_d[wa_phys] = wval;
    if (bulk_en) begin
      for (int k = 0; k < ROT; k++)
        bits_d[AW'(rot_map(idx_t'(START + k), idx_t'(START), idx_t'(ROT), idx_t'(base_i)))] = bulk_val[k];
    end
    if (top_en) bits_d[top_phys] = top_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  a_r2_pr_low_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wa_idx) < START) |-> (wa_phys == wa_idx));
  a_r3_pr_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= START) |-> (int'(rd_phys) >= START));
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rrf_pkg::*;
#(
  parameter int DW          = 16,
  parameter int GR_NUM      = 64,
  parameter int GR_START    = 32,
  parameter int PR_NUM      = 64,
  parameter int PR_START    = 16,
  localparam int GR_AW      = $clog2(GR_NUM),
  localparam int PR_AW      = $clog2(PR_NUM),
  localparam int GR_ROT_MAX = GR_NUM - GR_START,
  localparam int GR_SW      = $clog2(GR_ROT_MAX + 1),
  localparam int PR_ROT     = PR_NUM - PR_START,
  localparam int PR_BW      = $clog2(PR_ROT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rot_step,
  input  logic              rot_clear,
  input  logic [GR_SW-1:0]  cfg_rot_size,
  input  logic [GR_AW-1:0]  gr_ra_idx,
  output logic [DW-1:0]     gr_ra_data,
  input  logic [GR_AW-1:0]  gr_rb_idx,
  output logic [DW-1:0]     gr_rb_data,
  input  logic              gr_we,
  input  logic [GR_AW-1:0]  gr_wa_idx,
  input  logic [DW-1:0]     gr_wd,
  input  logic [PR_AW-1:0]  pr_rd_idx,
  output logic              pr_rd_val,
  input  logic              pr_we,
  input  logic [PR_AW-1:0]  pr_wa_idx,
  input  logic              pr_wval,
  input  logic              pr_bulk_en,
  input  logic [PR_ROT-1:0] pr_bulk_val,
  input  logic              pr_top_in,
  output logic [GR_SW-1:0]  gr_base,
  output logic [PR_BW-1:0]  pr_base
);
  logic [GR_SW-1:0] gr_size_eff;
  logic             rot_take;
  logic             pr_low_val;

  assign gr_size_eff = (int'(cfg_rot_size) > GR_ROT_MAX) ? GR_SW'(GR_ROT_MAX) : cfg_rot_size;
  assign rot_take    = rot_step && !rot_clear;

  rrf_base_ctr #(.BW(GR_SW)) u_gr_base (
    .clk(clk), .rst_n(rst_n), .step(rot_step), .clear(rot_clear),
    .size_i(gr_size_eff), .base_o(gr_base)
  );

  rrf_base_ctr #(.BW(PR_BW)) u_pr_base (
    .clk(clk), .rst_n(rst_n), .step(rot_step), .clear(rot_clear),
    .size_i(PR_BW'(PR_ROT)), .base_o(pr_base)
  );

  rrf_gr_file #(.DW(DW), .NUM(GR_NUM), .AW(GR_AW), .START(GR_START), .SW(GR_SW)) u_gr (
    .clk(clk), .rst_n(rst_n), .size_i(gr_size_eff), .base_i(gr_base),
    .ra_idx(gr_ra_idx), .ra_data(gr_ra_data), .rb_idx(gr_rb_idx), .rb_data(gr_rb_data),
    .we(gr_we), .wa_idx(gr_wa_idx), .wd(gr_wd)
  );

  rrf_pr_file #(.NUM(PR_NUM), .AW(PR_AW), .START(PR_START), .BW(PR_BW)) u_pr (
    .clk(clk), .rst_n(rst_n), .base_i(pr_base),
    .rd_idx(pr_rd_idx), .rd_val(pr_rd_val),
    .we(pr_we), .wa_idx(pr_wa_idx), .wval(pr_wval),
    .bulk_en(pr_bulk_en), .bulk_val(pr_bulk_val),
    .top_en(rot_take), .top_val(pr_top_in), .low_val(pr_low_val)
  );

  a_r9_top_wraps_low: assert property (@(posedge clk) disable iff (!rst_n)
    rot_take |=> (pr_low_val == $past(pr_top_in)));
  a_r8_bulk_sets_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_bulk_en && !rot_take) |=> (pr_low_val == $past(pr_bulk_val[0])));
  a_r6_size_limited: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (int'(gr_base) < GR_ROT_MAX || gr_size_eff == '0 || int'(gr_base) < int'(gr_size_eff)));
endmodule

// File: tb/test_rot_regfile.sv
module test_rot_regfile;
  localparam int DW = 16, NG = 64, GS = 32, NP = 64, PS = 16, PROT = 48, GMAX = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rot_step, rot_clear;
  logic [5:0] cfg_rot_size;
  logic [5:0] gr_ra_idx, gr_rb_idx, gr_wa_idx, pr_rd_idx, pr_wa_idx;
  logic [DW-1:0] gr_ra_data, gr_rb_data, gr_wd;
  logic gr_we, pr_rd_val, pr_we, pr_wval, pr_bulk_en, pr_top_in;
  logic [PROT-1:0] pr_bulk_val;
  logic [5:0] gr_base, pr_base;

  rot_regfile i_rot_regfile (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] gm [NG];
  logic pm [NP];
  int gsz = 0, gb = 0, pb = 0;

  task automatic expect_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rot_step = 0; rot_clear = 0; gr_we = 0; pr_we = 0; pr_bulk_en = 0; pr_top_in = 0;
  endtask

  // Requirement-level model in the logical view.
  task automatic apply();
    @(posedge clk);
    if (gr_we) gm[gr_wa_idx] = gr_wd;
    if (pr_we) pm[pr_wa_idx] = pr_wval;
    if (pr_bulk_en) for (int k = 0; k < PROT; k++) pm[PS+k] = pr_bulk_val[k];
    if (rot_clear) begin
      gb = 0; pb = 0;
    end else if (rot_step) begin
      logic [DW-1:0] gt;
      logic pt;
      pm[NP-1] = pr_top_in;
      if (gsz > 0) begin
        gt = gm[GS+gsz-1];
        for (int n = GS + gsz - 1; n > GS; n--) gm[n] = gm[n-1];
        gm[GS] = gt;
        gb = (gb == 0) ? gsz - 1 : gb - 1;
      end
      pt = pm[NP-1];
      for (int n = NP - 1; n > PS; n--) pm[n] = pm[n-1];
      pm[PS] = pt;
      pb = (pb == 0) ? PROT - 1 : pb - 1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic check_bases(string tag);
    expect_eq(tag, "gr_base", 32'(gr_base), 32'(gb));
    expect_eq(tag, "pr_base", 32'(pr_base), 32'(pb));
  endtask

  task automatic scan_all(string tag);
    for (int i = 0; i < NG; i++) begin
      gr_ra_idx = 6'(i); gr_rb_idx = 6'(NG - 1 - i); pr_rd_idx = 6'(i);
      #1;
      expect_eq(tag, $sformatf("gr A[%0d]", i), 32'(gr_ra_data), 32'(gm[i]));
      expect_eq(tag, $sformatf("gr B[%0d]", NG - 1 - i), 32'(gr_rb_data), 32'(gm[NG-1-i]));
      expect_eq(tag, $sformatf("pr[%0d]", i), 32'(pr_rd_val), 32'(pm[i]));
    end
    check_bases(tag);
  endtask

  task automatic read_gr(string tag, int idx, logic [DW-1:0] exp);
    gr_ra_idx = 6'(idx); #1;
    expect_eq(tag, $sformatf("gr[%0d]", idx), 32'(gr_ra_data), 32'(exp));
  endtask

  task automatic read_pr(string tag, int idx, logic exp);
    pr_rd_idx = 6'(idx); #1;
    expect_eq(tag, $sformatf("pr[%0d]", idx), 32'(pr_rd_val), 32'(exp));
  endtask

  task automatic reload(int salt);
    for (int i = 0; i < NG; i++) begin
      gr_we = 1; gr_wa_idx = 6'(i); gr_wd = DW'(i * 16'h0101 ^ salt); apply();
    end
    pr_bulk_en = 1; pr_bulk_val = {$urandom, $urandom}; apply();
    for (int i = 0; i < PS; i++) begin
      pr_we = 1; pr_wa_idx = 6'(i); pr_wval = 1'((i + salt) & 1); apply();
    end
  endtask

  task automatic set_cfg(int c);
    cfg_rot_size = 6'(c);
    gsz = (c > GMAX) ? GMAX : c;
    rot_clear = 1; apply();
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    idle(); cfg_rot_size = 6'd8; gsz = 8;
    gr_ra_idx = 0; gr_rb_idx = 0; gr_wa_idx = 0; gr_wd = 0;
    pr_rd_idx = 0; pr_wa_idx = 0; pr_wval = 0; pr_bulk_val = '0;
    for (int i = 0; i < NG; i++) gm[i] = '0;
    for (int i = 0; i < NP; i++) pm[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    scan_all("R1");

    // Size 8 window, one rotation.
    reload(16'h3c00);
    scan_all("R3");
    rot_step = 1; pr_top_in = 1; apply();
    read_gr("R4", 33, DW'(32 * 16'h0101 ^ 16'h3c00));
    read_gr("R4", 32, DW'(39 * 16'h0101 ^ 16'h3c00));
    read_gr("R3", 40, DW'(40 * 16'h0101 ^ 16'h3c00));
    read_gr("R2", 5, DW'(5 * 16'h0101 ^ 16'h3c00));
    read_pr("R9", 16, 1'b1);
    scan_all("R4");

    // Base wraps, seven more steps back to zero.
    for (int s = 0; s < 7; s++) begin
      rot_step = 1; pr_top_in = 1'(s & 1); apply();
      check_bases("R5");
    end
    expect_eq("R5", "gr_base back to 0", 32'(gr_base), 32'd0);
    scan_all("R2");

    // Same-cycle write and step use the old base.
    gr_we = 1; gr_wa_idx = 6'd32; gr_wd = 16'hbeef; rot_step = 1; apply();
    read_gr("R7", 33, 16'hbeef);
    scan_all("R7");

    // Clear with step when bases are already zero: step has no effect.
    set_cfg(8); reload(16'h0a50);
    rot_clear = 1; rot_step = 1; pr_top_in = ~pm[NP-1]; apply();
    scan_all("R5");

    // Bulk beats explicit write, top beats bulk.
    pr_bulk_en = 1; pr_bulk_val = 48'h0000_0000_0010; pr_we = 1; pr_wa_idx = 6'd20; pr_wval = 0; apply();
    read_pr("R8", 20, 1'b1);
    read_pr("R8", 17, 1'b0);
    pr_bulk_en = 1; pr_bulk_val = '0; rot_step = 1; pr_top_in = 1; apply();
    read_pr("R9", 16, 1'b1);
    read_pr("R8", 17, 1'b0);
    scan_all("R8");

    // Size zero disables general renaming.
    set_cfg(0); reload(16'h1234);
    for (int s = 0; s < 3; s++) begin rot_step = 1; apply(); end
    expect_eq("R6", "gr_base with size 0", 32'(gr_base), 32'd0);
    scan_all("R6");

    // Oversized config is limited to the full window.
    set_cfg(40); reload(16'h7777);
    rot_step = 1; apply();
    read_gr("R6", 32, DW'(63 * 16'h0101 ^ 16'h7777));
    expect_eq("R6", "gr_base limited", 32'(gr_base), 32'(GMAX - 1));
    scan_all("R6");

    // Random phase.
    set_cfg(13); reload(16'h0f0f);
    for (int it = 0; it < 3000; it++) begin
      gr_we = 1'($urandom_range(0, 1)); gr_wa_idx = 6'($urandom_range(0, 63)); gr_wd = DW'($urandom);
      pr_we = 1'($urandom_range(0, 1)); pr_wa_idx = 6'($urandom_range(0, 63)); pr_wval = 1'($urandom);
      pr_bulk_en = ($urandom_range(0, 19) == 0); pr_bulk_val = {$urandom, $urandom};
      rot_step = ($urandom_range(0, 9) < 3); pr_top_in = 1'($urandom);
      apply();
      gr_ra_idx = 6'($urandom_range(0, 63)); gr_rb_idx = 6'($urandom_range(0, 63));
      pr_rd_idx = 6'($urandom_range(0, 63));
      #1;
      expect_eq("R10", "rand gr A", 32'(gr_ra_data), 32'(gm[gr_ra_idx]));
      expect_eq("R10", "rand gr B", 32'(gr_rb_data), 32'(gm[gr_rb_idx]));
      expect_eq("R4", "rand pr", 32'(pr_rd_val), 32'(pm[pr_rd_idx]));
      check_bases("R5");
    end
    scan_all("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule